// File: doc/BRIEF.md
# Thread Context Issue Scheduler

This block decides which of several hardware thread contexts owns the single issue slot of a data-path micro-engine. Every context carries a blocked flag. The running context keeps the slot until the pipeline reports a stall for it. That stall could come from a memory access or a busy functional unit. The stalling context is then marked blocked and the scheduler hands the slot to another context that is ready.

A switch is not free. After each handover the pipeline must drain, so the issue slot stays empty for a fixed number of flush cycles. During those cycles the output already names the incoming context. If every context is blocked when a stall arrives, the whole engine goes idle. It stays idle until a completion signal wakes at least one context, and then it resumes through the same flush.

The pipeline, register files and memory units are outside this block. They appear only as the stall input and the per-context wake inputs. The default configuration has four contexts and a three-cycle flush.

Top module: `ctx_sched`

## Requirements
- R1: After reset no context is blocked, context 0 owns the slot, `issue_o` is 1 and `idle_o` is 0.
- R2: While `issue_o` is 1 and `stall_i` is 0, `ctx_o` and `issue_o` do not change. A wake for a context that is already ready has no visible effect.
- R3: When `stall_i` is 1 while `issue_o` is 1, the running context becomes blocked and a replacement is searched for. The search starts at the running index plus one and wraps modulo the context count. The running context is checked last. The first ready context found is taken.
- R4: Bit i of `wake_i` clears the blocked flag of context i. A wake counts as ready in the same cycle's search.
- R5: If the running context stalls and `wake_i` for that same context is 1 in the same cycle, the context stays blocked.
- R6: After each switch, `issue_o` is 0 for exactly FLUSH_CYC cycles (3 by default) and then returns to 1. From the first flush cycle onward, `ctx_o` shows the incoming context in binary and holds it steady.
- R7: If a stall leaves no context ready, `idle_o` goes to 1 and `issue_o` to 0 in the next cycle, with `ctx_o` unchanged. The engine stays idle while `wake_i` is all zero.
- R8: When one or more contexts wake while the engine is idle, a context is chosen in the next cycle. The choice is the first woken one in round-robin order after the last running context, with that context itself checked last. The flush of R6 is then charged.
- R9: `stall_i` has no effect while `issue_o` is 0, whether the engine is flushing or idle.
- R10: `issue_o` and `idle_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Running context stalled this cycle |
| wake_i | input | NUM_CTX | Per-context completion; bit i unblocks context i |
| ctx_o | output | $clog2(NUM_CTX) | Binary index of the context owning the slot |
| issue_o | output | 1 | Slot may issue for `ctx_o` this cycle |
| idle_o | output | 1 | Every context blocked, engine waiting |

## Verification
The assertions assume that both inputs are known values after reset. They also assume that `stall_i` always refers to the context shown on `ctx_o`, so a stall on a non-issuing cycle is simply dropped. Wakes are treated as one-cycle pulses per context that may coincide with anything.

The stimulus changes inputs only between clock edges and keeps them at zero on all other cycles. It raises `stall_i` on purpose during flush and idle cycles. It also drives wakes that collide with a stall of the same context or of another context, and wakes that select a context across the wrap point.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_FLUSH = 2'd1,
        ST_IDLE  = 2'd2
    } sched_st_e;

endpackage

// File: rtl/ctx_status.sv
// Per-context blocked flags. The next-state vector is exported so the
// picker sees wakes and the current stall in the same cycle.
module ctx_status #(
    parameter int NUM_CTX = 4,
    localparam int CW     = $clog2(NUM_CTX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [CW-1:0]      set_idx,
    input  logic [NUM_CTX-1:0] wake_i,
    output logic [NUM_CTX-1:0] blk_d
);

    logic [NUM_CTX-1:0] blk_q;

    always_comb begin
        blk_d = blk_q & ~wake_i;
        // a stall overrides a wake for the same context
        if (set_en) begin
            blk_d[set_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= '0;
        end else begin
            blk_q <= blk_d;
        end
    end

endmodule

// File: rtl/rr_pick.sv
// Round-robin search: base+1, base+2, ..., base (base itself last).
module rr_pick #(
    parameter int NUM_CTX = 4,
    localparam int CW     = $clog2(NUM_CTX)
) (
    input  logic [NUM_CTX-1:0] ready,
    input  logic [CW-1:0]      base,
    output logic               hit,
    output logic [CW-1:0]      sel
);

    always_comb begin
        hit = 1'b0;
        sel = base;
        // walk from farthest to nearest so the nearest hit is kept
        for (int k = NUM_CTX; k >= 1; k--) begin
            int pos;
            pos = (int'(base) + k) % NUM_CTX;
            if (ready[pos]) begin
                hit = 1'b1;
                sel = CW'(pos);
            end
        end
    end

endmodule

// File: rtl/flush_timer.sv
// Counts the pipeline drain after a switch; done is high on the last flush cycle.
module flush_timer #(
    parameter int FLUSH_CYC = 3,
    localparam int TW       = $clog2(FLUSH_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = TW'(FLUSH_CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/ctx_sched.sv
module ctx_sched #(
    parameter int NUM_CTX   = 4,
    parameter int FLUSH_CYC = 3,
    localparam int CW       = $clog2(NUM_CTX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall_i,
    input  logic [NUM_CTX-1:0] wake_i,
    output logic [CW-1:0]      ctx_o,
    output logic               issue_o,
    output logic               idle_o
);
    import ctx_sched_pkg::*;

    typedef struct packed {
        sched_st_e     st;
        logic [CW-1:0] ctx;
    } sched_t;

    sched_t             sch_d, sch_q;
    logic               set_en;
    logic               load;
    logic               fl_done;
    logic               hit;
    logic [CW-1:0]      sel;
    logic [NUM_CTX-1:0] blk_d;

    // only a stall while issuing is accepted
    assign set_en = (sch_q.st == ST_RUN) && stall_i;

    ctx_status #(.NUM_CTX(NUM_CTX)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (set_en),
        .set_idx (sch_q.ctx),
        .wake_i  (wake_i),
        .blk_d   (blk_d)
    );

    rr_pick #(.NUM_CTX(NUM_CTX)) u_pick (
        .ready (~blk_d),
        .base  (sch_q.ctx),
        .hit   (hit),
        .sel   (sel)
    );

    flush_timer #(.FLUSH_CYC(FLUSH_CYC)) u_flush (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .done  (fl_done)
    );

    always_comb begin
        sch_d = sch_q;
        load  = 1'b0;
        case (sch_q.st)
            ST_RUN: begin
                if (stall_i) begin
                    if (hit) begin
                        sch_d.ctx = sel;
                        sch_d.st  = ST_FLUSH;
                        load      = 1'b1;
                    end else begin
                        sch_d.st  = ST_IDLE;
                    end
                end
            end
            ST_FLUSH: begin
                if (fl_done) begin
                    sch_d.st = ST_RUN;
                end
            end
            ST_IDLE: begin
                if (hit) begin
                    sch_d.ctx = sel;
                    sch_d.st  = ST_FLUSH;
                    load      = 1'b1;
                end
            end
            default: sch_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sch_q <= '{st: ST_RUN, ctx: '0};
        end else begin
            sch_q <= sch_d;
        end
    end

    assign ctx_o   = sch_q.ctx;
    assign issue_o = (sch_q.st == ST_RUN);
    assign idle_o  = (sch_q.st == ST_IDLE);

endmodule

// File: rtl/ctx_sched_chk.sv
module ctx_sched_chk #(
    parameter int NUM_CTX   = 4,
    parameter int FLUSH_CYC = 3,
    localparam int CW       = $clog2(NUM_CTX)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               stall_i,
    input logic [NUM_CTX-1:0] wake_i,
    input logic [CW-1:0]      ctx_o,
    input logic               issue_o,
    input logic               idle_o
);

    int fl_run;

    // length of the current stretch of flush cycles seen at the ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_run <= 0;
        end else if (!issue_o && !idle_o) begin
            fl_run <= fl_run + 1;
        end else begin
            fl_run <= 0;
        end
    end

    AST_EXCL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_o && idle_o)); // R10

    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o && !stall_i) |=> (issue_o && $stable(ctx_o))); // R2

    AST_STALL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o && stall_i) |=> !issue_o); // R3

    AST_SWITCH_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o && stall_i) |=> (idle_o || (ctx_o != $past(ctx_o)))); // R3

    AST_FLUSH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_o && !idle_o) |=> $stable(ctx_o)); // R6

    AST_FLUSH_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_o && !idle_o) |-> (fl_run < FLUSH_CYC)); // R6

    AST_FLUSH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(issue_o) |-> ($past(fl_run) == FLUSH_CYC - 1)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && (wake_i == '0)) |=> (idle_o && $stable(ctx_o))); // R7

    AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && (wake_i != '0)) |=> (!idle_o && !issue_o)); // R8

endmodule

bind ctx_sched ctx_sched_chk #(
    .NUM_CTX   (NUM_CTX),
    .FLUSH_CYC (FLUSH_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall_i (stall_i),
    .wake_i  (wake_i),
    .ctx_o   (ctx_o),
    .issue_o (issue_o),
    .idle_o  (idle_o)
);

// File: tb/sim_ctx_sched.sv
`timescale 1ns/1ps
module sim_ctx_sched;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stall_i = 1'b0;
    logic [3:0] wake_i = 4'b0000;
    logic [1:0] ctx_o;
    logic       issue_o;
    logic       idle_o;

    typedef struct {
        logic [1:0] ctx;
        logic       iss;
        logic       idl;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;

    always #4 clk = ~clk;

    ctx_sched #(.NUM_CTX(4), .FLUSH_CYC(3)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall_i (stall_i),
        .wake_i  (wake_i),
        .ctx_o   (ctx_o),
        .issue_o (issue_o),
        .idle_o  (idle_o)
    );

    task automatic compare(input exp_t e);
        n_chk++;
        if (ctx_o !== e.ctx || issue_o !== e.iss || idle_o !== e.idl) begin
            n_fail++;
            $display("FAIL %s: got ctx=%0d issue=%0b idle=%0b, expected ctx=%0d issue=%0b idle=%0b",
                     e.tag, ctx_o, issue_o, idle_o, e.ctx, e.iss, e.idl);
        end
    endtask

    // driver: one call per clock edge, expectation is the state after that edge
    task automatic step(input logic st, input logic [3:0] wk, input logic [1:0] ectx,
                        input logic eiss, input logic eidl, input string tag);
        exp_t e;
        @(negedge clk);
        stall_i = st;
        wake_i  = wk;
        e.ctx = ectx; e.iss = eiss; e.idl = eidl; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // remaining two flush cycles, then issue resumes
    task automatic finish_flush(input logic [1:0] c);
        step(1'b0, 4'b0000, c, 1'b0, 1'b0, "R6 flush");
        step(1'b0, 4'b0000, c, 1'b0, 1'b0, "R6 flush");
        step(1'b0, 4'b0000, c, 1'b1, 1'b0, "R6 issue resumes");
    endtask

    // monitor: pops one expectation per edge, samples after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                compare(sb_q.pop_front());
            end
        end
    end

    initial begin
        #(8 * 5000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, got hang, expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        r.ctx = 2'd0; r.iss = 1'b1; r.idl = 1'b0; r.tag = "R1 reset state";
        compare(r);

        // R3 stall on 0 -> 1
        step(1'b1, 4'b0000, 2'd1, 1'b0, 1'b0, "R3 switch 0->1");
        finish_flush(2'd1);
        // R2 hold, wake of a ready context is harmless
        step(1'b0, 4'b0000, 2'd1, 1'b1, 1'b0, "R2 hold");
        step(1'b0, 4'b0010, 2'd1, 1'b1, 1'b0, "R2 wake of ready ctx");
        // stall on 1 -> 2, stalls during flush dropped
        step(1'b1, 4'b0000, 2'd2, 1'b0, 1'b0, "R3 switch 1->2");
        step(1'b1, 4'b0000, 2'd2, 1'b0, 1'b0, "R9 stall in flush");
        step(1'b1, 4'b0000, 2'd2, 1'b0, 1'b0, "R9 stall in flush");
        step(1'b0, 4'b0000, 2'd2, 1'b1, 1'b0, "R9 issue on time");
        // R4 wake context 0
        step(1'b0, 4'b0001, 2'd2, 1'b1, 1'b0, "R4 wake 0");
        step(1'b1, 4'b0000, 2'd3, 1'b0, 1'b0, "R3 switch 2->3");
        finish_flush(2'd3);
        step(1'b1, 4'b0000, 2'd0, 1'b0, 1'b0, "R3 wrap 3->0");
        finish_flush(2'd0);
        // R5 stall and wake of 0 together, all blocked -> idle
        step(1'b1, 4'b0001, 2'd0, 1'b0, 1'b1, "R5 R7 stays blocked, idle");
        step(1'b1, 4'b0000, 2'd0, 1'b0, 1'b1, "R9 stall in idle");
        step(1'b0, 4'b0000, 2'd0, 1'b0, 1'b1, "R7 idle holds");
        // R8 wake 0 and 3 together: 3 comes first after 0
        step(1'b0, 4'b1001, 2'd3, 1'b0, 1'b0, "R8 idle exit picks 3");
        finish_flush(2'd3);
        step(1'b1, 4'b0000, 2'd0, 1'b0, 1'b0, "R3 switch 3->0");
        finish_flush(2'd0);
        // R4 same-cycle wake of another context is selectable
        step(1'b1, 4'b0100, 2'd2, 1'b0, 1'b0, "R4 same-cycle wake 2");
        finish_flush(2'd2);
        step(1'b1, 4'b0000, 2'd2, 1'b0, 1'b1, "R7 idle keeps ctx 2");
        step(1'b0, 4'b0000, 2'd2, 1'b0, 1'b1, "R7 idle holds");
        step(1'b0, 4'b0100, 2'd2, 1'b0, 1'b0, "R8 own ctx checked last");
        finish_flush(2'd2);
        step(1'b0, 4'b0000, 2'd2, 1'b1, 1'b0, "R2 R10 steady run");

        wait (sb_q.size() == 0);
        @(negedge clk);
        stall_i = 1'b0;
        wake_i  = 4'b0000;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule